// File: doc/BRIEF.md
# Serial Configuration Front End with Latch Routing

This block receives configuration words over a three-wire serial link (serial clock, serial data, load strobe) and turns them into the decoded settings for a frequency synthesizer's counters and control logic. Bits arrive most significant first, one on each rising serial clock edge. A 24-bit shift register always holds the most recent 24 bits. When the load strobe rises, the two lowest bits of that word act as an address: they pick one of three configuration latches, and the word is copied into it. The three latches are laid out differently: a reference divide ratio, an N-divider latch, and a function latch.

The three serial inputs are asynchronous to the system clock. Each one passes through a synchroniser of `SYNC_STAGES` flops, and edges are detected in the system clock domain. A control module turns the detected edges into a small registered strobe bundle, and a datapath module acts on it. The charge-pump gain bit in the N latch has a hardware clear input, so a timer elsewhere can drop the fast-lock gain without reprogramming the link.

Top module: `ser_cfg_front`

## Requirements
- R1: After reset every output is 0.
- R2: A word is the last 24 bits shifted in before the load strobe rises, most significant bit first. Any earlier bits drop out, and serial clock edges without a load strobe change no output.
- R3: Address 00 (word bits 1:0) loads `refDiv` from word bits 15:2. Word bits 23:16 are ignored, and all other outputs keep their values.
- R4: Address 01 loads `aCnt` from bits 7:2, `bCnt` from bits 20:8 and `cpGain` from bit 21, and leaves all other outputs unchanged.
- R5: Address 10 loads the function fields and leaves all other outputs unchanged. The fields are: `cntRst` bit 2, `swPd` bit 3, `muxSel` bits 6:4, `pdPol` bit 7, `cpTri` bit 8, `flEn` bit 9, `flMode` bit 10, `timerCode` bits 14:11, `curSet1` bits 17:15, `curSet2` bits 20:18, `pdRsvd` bit 21 and `prescSel` bits 23:22.
- R6: Address 11 is ignored, and no output changes.
- R7: With `SYNC_STAGES` = 2, a load appears on the fourth rising `sysClk` edge after the load strobe rises. The output still holds its old value after the third edge.
- R8: A high `gainClr` clears `cpGain` at the next `sysClk` edge and leaves every other output unchanged.
- R9: If `gainClr` and a load of the N latch fall on the same edge, the load wins, and `cpGain` takes word bit 21.
- R10: Loading and latching keep working while `swPd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock, asynchronous |
| serData | input | 1 | Serial data, MSB first |
| serLe | input | 1 | Load strobe, acts on its rising edge |
| gainClr | input | 1 | Hardware clear of the gain bit |
| refDiv | output | 14 | Reference divide ratio |
| aCnt | output | 6 | Swallow counter value |
| bCnt | output | 13 | Main counter value |
| cpGain | output | 1 | Fast-lock gain bit |
| cntRst | output | 1 | Counters held in reset |
| swPd | output | 1 | Software power-down |
| muxSel | output | 3 | Output multiplexer select |
| pdPol | output | 1 | Phase detector polarity |
| cpTri | output | 1 | Charge pump three-state |
| flEn | output | 1 | Fast-lock enable |
| flMode | output | 1 | Fast-lock mode |
| timerCode | output | 4 | Fast-lock timeout code |
| curSet1 | output | 3 | Charge pump current, setting 1 |
| curSet2 | output | 3 | Charge pump current, setting 2 |
| pdRsvd | output | 1 | Reserved power-down bit |
| prescSel | output | 2 | Prescaler modulus select |

## Verification
A load-strobe rise takes `SYNC_STAGES` edges to pass the synchroniser, one edge in the strobe register and one edge in the latch. With the default setting that is four system clock edges. A `gainClr` acts one edge after it is sampled. In the bench, inputs change on the falling system clock edge. General checks wait twelve cycles after the strobe falls. The latency and collision checks count edges one by one instead: they sample after the third edge, where the old value is expected, and after the fourth edge, where the new value is expected. `gainClr` is raised so that it is sampled on exactly the edge that loads the latch.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;

  localparam int WORD_W    = 24;
  localparam int ADDR_W    = 2;
  localparam int REF_W     = 14;
  localparam int A_W       = 6;
  localparam int B_W       = 13;
  localparam int FUNC_W    = WORD_W - ADDR_W;
  localparam int GAIN_POS  = 21;

  typedef enum logic [ADDR_W-1:0] {
    SEL_REF  = 2'b00,
    SEL_N    = 2'b01,
    SEL_FUNC = 2'b10,
    SEL_NONE = 2'b11
  } latch_sel_e;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic loadEn;
  } strobe_t;

endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic sysClk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stage;
      always_ff @(posedge sysClk or negedge rstN) begin
        if (!rstN) stage <= 1'b0;
        else       stage <= d;
      end
      assign q = stage;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge sysClk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ser_cfg_ctrl.sv
module ser_cfg_ctrl
  import ser_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    sysClk,
  input  logic    rstN,
  input  logic    serClk,
  input  logic    serData,
  input  logic    serLe,
  output strobe_t strb
);

  localparam int N_IN = 3;

  logic [N_IN-1:0] rawVec;
  logic [N_IN-1:0] syncVec;
  logic            clkPrev;
  logic            lePrev;

  assign rawVec = {serLe, serData, serClk};

  generate
    for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
      ser_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .sysClk (sysClk),
        .rstN   (rstN),
        .d      (rawVec[gi]),
        .q      (syncVec[gi])
      );
    end
  endgenerate

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      lePrev  <= 1'b0;
      strb    <= '0;
    end else begin
      clkPrev       <= syncVec[0];
      lePrev        <= syncVec[2];
      strb.shiftEn  <= syncVec[0] & ~clkPrev;
      strb.shiftBit <= syncVec[1];
      strb.loadEn   <= syncVec[2] & ~lePrev;
    end
  end

  AST_LOAD_SINGLE_PULSE: assert property (@(posedge sysClk) disable iff (!rstN)
    strb.loadEn |=> !strb.loadEn); // R7
  AST_SHIFT_SINGLE_PULSE: assert property (@(posedge sysClk) disable iff (!rstN)
    strb.shiftEn |=> !strb.shiftEn); // R2

endmodule

// File: rtl/ser_cfg_dp.sv
module ser_cfg_dp
  import ser_cfg_pkg::*;
(
  input  logic              sysClk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              gainClr,
  output logic [REF_W-1:0]  refLat,
  output logic [A_W-1:0]    aLat,
  output logic [B_W-1:0]    bLat,
  output logic              gainLat,
  output logic [FUNC_W-1:0] funcLat
);

  localparam int A_LO = ADDR_W;
  localparam int B_LO = A_LO + A_W;

  logic [WORD_W-1:0] shiftReg;
  latch_sel_e        sel;
  logic              loadRef;
  logic              loadN;
  logic              loadFunc;

  assign sel      = latch_sel_e'(shiftReg[ADDR_W-1:0]);
  assign loadRef  = strb.loadEn && (sel == SEL_REF);
  assign loadN    = strb.loadEn && (sel == SEL_N);
  assign loadFunc = strb.loadEn && (sel == SEL_FUNC);

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], strb.shiftBit};
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      refLat  <= '0;
      aLat    <= '0;
      bLat    <= '0;
      funcLat <= '0;
    end else begin
      if (loadRef)  refLat  <= shiftReg[ADDR_W +: REF_W];
      if (loadN) begin
        aLat <= shiftReg[A_LO +: A_W];
        bLat <= shiftReg[B_LO +: B_W];
      end
      if (loadFunc) funcLat <= shiftReg[WORD_W-1:ADDR_W];
    end
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)        gainLat <= 1'b0;
    else if (loadN)   gainLat <= shiftReg[GAIN_POS];
    else if (gainClr) gainLat <= 1'b0;
  end

  AST_REF_HOLD: assert property (@(posedge sysClk) disable iff (!rstN)
    !(strb.loadEn && shiftReg[1:0] == 2'b00) |=> $stable(refLat)); // R3
  AST_FUNC_HOLD: assert property (@(posedge sysClk) disable iff (!rstN)
    !(strb.loadEn && shiftReg[1:0] == 2'b10) |=> $stable(funcLat)); // R5
  AST_ADDR11_IGNORED: assert property (@(posedge sysClk) disable iff (!rstN)
    (strb.loadEn && shiftReg[1:0] == 2'b11) |=>
      ($stable(refLat) && $stable(aLat) && $stable(bLat) && $stable(funcLat))); // R6
  AST_GAIN_CLEARED: assert property (@(posedge sysClk) disable iff (!rstN)
    (gainClr && !(strb.loadEn && shiftReg[1:0] == 2'b01)) |=> !gainLat); // R8
  AST_LOAD_BEATS_CLEAR: assert property (@(posedge sysClk) disable iff (!rstN)
    (strb.loadEn && shiftReg[1:0] == 2'b01) |=> (gainLat == $past(shiftReg[21]))); // R9

endmodule

// File: rtl/ser_cfg_front.sv
module ser_cfg_front
  import ser_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        sysClk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        serLe,
  input  logic        gainClr,
  output logic [13:0] refDiv,
  output logic [5:0]  aCnt,
  output logic [12:0] bCnt,
  output logic        cpGain,
  output logic        cntRst,
  output logic        swPd,
  output logic [2:0]  muxSel,
  output logic        pdPol,
  output logic        cpTri,
  output logic        flEn,
  output logic        flMode,
  output logic [3:0]  timerCode,
  output logic [2:0]  curSet1,
  output logic [2:0]  curSet2,
  output logic        pdRsvd,
  output logic [1:0]  prescSel
);

  strobe_t           strb;
  logic [FUNC_W-1:0] funcLat;

  ser_cfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .sysClk  (sysClk),
    .rstN    (rstN),
    .serClk  (serClk),
    .serData (serData),
    .serLe   (serLe),
    .strb    (strb)
  );

  ser_cfg_dp u_dp (
    .sysClk  (sysClk),
    .rstN    (rstN),
    .strb    (strb),
    .gainClr (gainClr),
    .refLat  (refDiv),
    .aLat    (aCnt),
    .bLat    (bCnt),
    .gainLat (cpGain),
    .funcLat (funcLat)
  );

  // funcLat[k] holds word bit k+2
  assign cntRst    = funcLat[0];
  assign swPd      = funcLat[1];
  assign muxSel    = funcLat[4:2];
  assign pdPol     = funcLat[5];
  assign cpTri     = funcLat[6];
  assign flEn      = funcLat[7];
  assign flMode    = funcLat[8];
  assign timerCode = funcLat[12:9];
  assign curSet1   = funcLat[15:13];
  assign curSet2   = funcLat[18:16];
  assign pdRsvd    = funcLat[19];
  assign prescSel  = funcLat[21:20];

endmodule

// File: tb/ser_cfg_front_test.sv
module ser_cfg_front_test;

  logic sysClk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic serLe = 1'b0;
  logic gainClr = 1'b0;
  logic [13:0] refDiv;
  logic [5:0]  aCnt;
  logic [12:0] bCnt;
  logic cpGain, cntRst, swPd, pdPol, cpTri, flEn, flMode, pdRsvd;
  logic [2:0]  muxSel, curSet1, curSet2;
  logic [3:0]  timerCode;
  logic [1:0]  prescSel;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [13:0] mRef = '0;
  logic [5:0]  mA = '0;
  logic [12:0] mB = '0;
  logic        mG = 1'b0;
  logic [21:0] mFunc = '0;

  always #2 sysClk = ~sysClk;

  ser_cfg_front uut (
    .sysClk(sysClk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLe(serLe),
    .gainClr(gainClr), .refDiv(refDiv), .aCnt(aCnt), .bCnt(bCnt), .cpGain(cpGain),
    .cntRst(cntRst), .swPd(swPd), .muxSel(muxSel), .pdPol(pdPol), .cpTri(cpTri),
    .flEn(flEn), .flMode(flMode), .timerCode(timerCode), .curSet1(curSet1),
    .curSet2(curSet2), .pdRsvd(pdRsvd), .prescSel(prescSel)
  );

  localparam logic [23:0] VEC [8] = '{
    24'h000004,  // ref = 1
    24'h00FFFC,  // ref = 16383
    24'hFF0028,  // ref = 10, upper junk
    24'h1FFFFD,  // A=63 B=8191 G=0
    24'h200215,  // A=5 B=2 G=1
    24'hA5A5A6,  // function
    24'h5A5A5A,  // function
    24'hFFFFFF   // address 11
  };

  function automatic logic [21:0] funcOut();
    return {prescSel, pdRsvd, curSet2, curSet1, timerCode, flMode, flEn,
            cpTri, pdPol, muxSel, swPd, cntRst};
  endfunction

  task automatic modelLoad(input logic [23:0] w);
    case (w[1:0])
      2'b00: mRef = w[15:2];
      2'b01: begin mA = w[7:2]; mB = w[20:8]; mG = w[21]; end
      2'b10: mFunc = w[23:2];
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " ref"},  32'(refDiv), 32'(mRef));
    check({tag, " nlat"}, {12'd0, cpGain, bCnt, aCnt}, {12'd0, mG, mB, mA});
    check({tag, " func"}, 32'(funcOut()), 32'(mFunc));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge sysClk);
  endtask

  task automatic sendBits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = w[i];
      cyc(4);
      serClk = 1'b1;
      cyc(8);
      serClk = 1'b0;
      cyc(4);
    end
  endtask

  task automatic pulseLe();
    serLe = 1'b1;
    cyc(8);
    serLe = 1'b0;
    cyc(12);
  endtask

  initial begin
    repeat (150000) @(posedge sysClk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    checkAll("R1 reset");
    rstN = 1'b1;
    cyc(3);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      sendBits(32'(VEC[i]), 24);
      pulseLe();
      modelLoad(VEC[i]);
      case (VEC[i][1:0])
        2'b00: checkAll("R3 ref load");
        2'b01: checkAll("R4 n load");
        2'b10: checkAll("R5 func load");
        default: checkAll("R6 addr11 ignored");
      endcase
    end

    // R2: shifting without a load changes nothing, extra leading bits drop out
    sendBits(32'h3F, 6);
    sendBits(32'h002468, 24);
    checkAll("R2 shift without load");
    pulseLe();
    modelLoad(24'h002468);
    checkAll("R2 last 24 bits");

    // R8: clear gain; first load G1=1
    sendBits(32'h2A0A09, 24);
    pulseLe();
    modelLoad(24'h2A0A09);
    check("R8 gain set before clear", 32'(cpGain), 32'd1);
    gainClr = 1'b1;
    cyc(1);
    gainClr = 1'b0;
    mG = 1'b0;
    checkAll("R8 gain cleared");

    // R7 latency and R9 collision
    sendBits(32'h2B1235, 24);
    serLe = 1'b1;
    @(posedge sysClk); @(posedge sysClk); @(posedge sysClk);
    @(negedge sysClk);
    checkAll("R7 old value after third edge");
    gainClr = 1'b1;
    @(posedge sysClk);
    @(negedge sysClk);
    gainClr = 1'b0;
    modelLoad(24'h2B1235);
    checkAll("R7 new value after fourth edge");
    check("R9 load wins over clear", 32'(cpGain), 32'd1);
    cyc(4);
    serLe = 1'b0;
    cyc(12);

    // R10: programming while powered down
    sendBits(32'h00000A, 24);
    pulseLe();
    modelLoad(24'h00000A);
    check("R10 swPd set", 32'(swPd), 32'd1);
    sendBits(32'h001234, 24);
    pulseLe();
    modelLoad(24'h001234);
    checkAll("R10 load during power-down");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule